// File: doc/BRIEF.md
# Interrupt and Wake-Event Controller

This block collects up to 32 interrupt request lines for a small processor core and presents them through a 32-bit register interface. It keeps two separate banks of state. The interrupt bank decides what is delivered to the core. The event bank decides what may bring a sleeping core back. Each bank has an enable mask, a pending register and write-one set and clear addresses. A rising edge on a request line marks the line pending in both banks at once.

Toward the core, the block drives a request flag, the number of the highest pending enabled line and the byte address of that line's vector. Toward the clock gating logic, it drives a sleep request, which software raises through a control register. The sleep request drops by itself once an enabled event becomes pending. A wake flag is driven while such an event is holding a raised sleep request.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on `req_lines[n]` sets bit n of both the interrupt pending register and the event pending register at the next clock edge. A line held high does not set the bit again after it has been cleared.
- R2: Register byte offsets on `bus_addr` are: 0x00 interrupt enable, 0x04 interrupt pending, 0x08 interrupt set, 0x0C interrupt clear, 0x10 event enable, 0x14 event pending, 0x18 event set, 0x1C event clear, 0x20 sleep control. The enable registers read back the value written. The set and clear addresses, and any unmapped offset, read as zero.
- R3: Writing a mask to 0x08 or 0x18 sets exactly the masked bits of the matching pending register.
- R4: Writing a mask to 0x0C or 0x1C clears only the masked bits of the matching pending register and leaves the other bank untouched.
- R5: When a clear write and a rising edge hit the same bit in the same cycle, the bit ends up set.
- R6: `irq_req` is high exactly when at least one bit is set in both interrupt enable and interrupt pending. A pending bit that is not enabled has no effect.
- R7: When several enabled interrupts are pending, `irq_id` gives the highest line number. It is 0 when none is pending.
- R8: `irq_vec` equals 4 times `irq_id` (for example, line 23 gives 0x5C and line 31 gives 0x7C).
- R9: A write to 0x20 loads bit 0 of the data into `sleep_req`. Reading 0x20 returns `sleep_req` in bit 0.
- R10: When at least one bit is set in both event enable and event pending, `sleep_req` is cleared at the next clock edge, and this overrides a sleep write in the same cycle. `wake` is high while `sleep_req` is high and such an event is pending. Events that are not enabled leave `sleep_req` unchanged.
- R11: Writes to the pending offsets 0x04 and 0x14 are ignored.
- R12: After reset, all enables, pending bits and the sleep request are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 32 | Request lines, edge detected |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | 5 | Highest enabled pending line |
| irq_vec | output | 7 | Byte address of the selected line's vector |
| sleep_req | output | 1 | Sleep request to the clock gating logic |
| wake | output | 1 | An enabled event is releasing the sleep request |

## Verification
The hardest case to reach is a collision: a clear write and a fresh rising edge on the same bit in the same cycle, or a sleep write landing while an enabled event is already pending. Random traffic seldom lines these up, so directed steps create each collision deliberately. Long random runs then mix sparse line toggles with writes to every offset, including the read-only ones. A bench model follows every cycle and compares all outputs and the read data.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types of the interrupt/event controller.
// Assumes byte offsets on a 6-bit address, word aligned.
package irqc_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_INT_EN   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_INT_PEND = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_INT_SET  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_INT_CLR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_EVT_EN   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_EVT_PEND = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_EVT_SET  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_EVT_CLR  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_SLEEP    = 6'h20;

    // Per-bank decoded write strobes
    typedef struct packed {
        logic en_wr;
        logic set_wr;
        logic clr_wr;
    } bank_wr_t;
endpackage

// File: rtl/irqc_edge.sv
// Module: rising-edge detector for the request lines.
// Assumes the lines are already synchronous to clk.
module irqc_edge #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] rise
);
    logic [NUM_LINES-1:0] lines_q;

    // Remember the previous line levels
    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines;
    end

    // A bit rises when it is high now and was low before
    always_comb rise = lines & ~lines_q;
endmodule

// File: rtl/irqc_bank.sv
// Module: one enable/pending bank with write-one set and clear.
// Assumes at most one of the write strobes is active per cycle.
// A new edge wins over a clear of the same bit.
module irqc_bank #(
    parameter int NUM_LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  irqc_pkg::bank_wr_t    wr,
    input  logic [NUM_LINES-1:0]  wdata,
    input  logic [NUM_LINES-1:0]  rise,
    output logic [NUM_LINES-1:0]  en_q,
    output logic [NUM_LINES-1:0]  pend_q
);
    logic [NUM_LINES-1:0] set_mask;
    logic [NUM_LINES-1:0] clr_mask;
    logic [NUM_LINES-1:0] pend_d;

    // Build the set and clear masks from the strobes
    always_comb begin
        set_mask = wr.set_wr ? wdata : '0;
        clr_mask = wr.clr_wr ? wdata : '0;
        pend_d   = ((pend_q | set_mask) & ~clr_mask) | rise;
    end

    // Enable register, loaded by a full write
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (wr.en_wr) en_q <= wdata;
    end

    // Pending register update
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/irqc_prio.sv
// Module: finds the highest set bit of a request vector.
// Returns index 0 and any=0 when the vector is empty.
module irqc_prio #(
    parameter int NUM_LINES = 32,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 any,
    output logic [ID_W-1:0]      idx
);
    // Scan upward so the last hit (the highest line) wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
// Module: interrupt and wake-event controller top.
// Decodes the register bus, holds the two banks and the sleep bit,
// and selects the interrupt sent to the core.
// Assumes NUM_LINES <= 32 and one bus write per cycle.
module irqc_top #(
    parameter int NUM_LINES = 32,
    localparam int ID_W     = $clog2(NUM_LINES),
    localparam int VEC_W    = ID_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        req_lines,
    input  logic [irqc_pkg::ADDR_W-1:0] bus_addr,
    input  logic                        bus_we,
    input  logic [irqc_pkg::BUS_W-1:0]  bus_wdata,
    output logic [irqc_pkg::BUS_W-1:0]  bus_rdata,
    output logic                        irq_req,
    output logic [ID_W-1:0]             irq_id,
    output logic [VEC_W-1:0]            irq_vec,
    output logic                        sleep_req,
    output logic                        wake
);
    import irqc_pkg::*;

    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] int_en, int_pend, evt_en, evt_pend;
    logic [NUM_LINES-1:0] wdata_l;
    bank_wr_t             int_wr, evt_wr;
    logic                 sleep_wr;
    logic                 evt_hit;
    logic                 sleep_q;

    assign wdata_l = bus_wdata[NUM_LINES-1:0];

    irqc_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (req_lines),
        .rise  (rise)
    );

    // Decode the write strobes; pending offsets are read-only
    always_comb begin
        int_wr.en_wr  = bus_we && (bus_addr == OFS_INT_EN);
        int_wr.set_wr = bus_we && (bus_addr == OFS_INT_SET);
        int_wr.clr_wr = bus_we && (bus_addr == OFS_INT_CLR);
        evt_wr.en_wr  = bus_we && (bus_addr == OFS_EVT_EN);
        evt_wr.set_wr = bus_we && (bus_addr == OFS_EVT_SET);
        evt_wr.clr_wr = bus_we && (bus_addr == OFS_EVT_CLR);
        sleep_wr      = bus_we && (bus_addr == OFS_SLEEP);
    end

    irqc_bank #(.NUM_LINES(NUM_LINES)) u_int_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (int_wr),
        .wdata  (wdata_l),
        .rise   (rise),
        .en_q   (int_en),
        .pend_q (int_pend)
    );

    irqc_bank #(.NUM_LINES(NUM_LINES)) u_evt_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (evt_wr),
        .wdata  (wdata_l),
        .rise   (rise),
        .en_q   (evt_en),
        .pend_q (evt_pend)
    );

    irqc_prio #(.NUM_LINES(NUM_LINES)) u_prio (
        .req (int_en & int_pend),
        .any (irq_req),
        .idx (irq_id)
    );

    // Vector byte address: one word per line
    always_comb irq_vec = {irq_id, 2'b00};

    // Any enabled event pending
    always_comb evt_hit = |(evt_en & evt_pend);

    // Sleep bit: an enabled event overrides a software write
    always_ff @(posedge clk) begin
        if (!rst_n)        sleep_q <= 1'b0;
        else if (evt_hit)  sleep_q <= 1'b0;
        else if (sleep_wr) sleep_q <= bus_wdata[0];
    end

    // Drive the clock gating outputs
    always_comb begin
        sleep_req = sleep_q;
        wake      = sleep_q && evt_hit;
    end

    // Read mux; write-only and unmapped offsets return zero
    always_comb begin
        unique case (bus_addr)
            OFS_INT_EN:   bus_rdata = BUS_W'(int_en);
            OFS_INT_PEND: bus_rdata = BUS_W'(int_pend);
            OFS_EVT_EN:   bus_rdata = BUS_W'(evt_en);
            OFS_EVT_PEND: bus_rdata = BUS_W'(evt_pend);
            OFS_SLEEP:    bus_rdata = BUS_W'(sleep_q);
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: assertion checker for irqc_top, attached by bind.
// Observes the bank state and the core-side outputs.
module irqc_checker #(
    parameter int NUM_LINES = 32,
    localparam int ID_W     = $clog2(NUM_LINES),
    localparam int VEC_W    = ID_W + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] rise,
    input logic [NUM_LINES-1:0] int_en,
    input logic [NUM_LINES-1:0] int_pend,
    input logic [NUM_LINES-1:0] evt_en,
    input logic [NUM_LINES-1:0] evt_pend,
    input logic                 irq_req,
    input logic [ID_W-1:0]      irq_id,
    input logic [VEC_W-1:0]     irq_vec,
    input logic                 sleep_req
);
    logic [NUM_LINES-1:0] masked;
    assign masked = int_en & int_pend;

    // R1 and R5: every rising edge is pending in both banks at the next edge
    a_r1_edge_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> (((int_pend & $past(rise)) == $past(rise)) &&
                     ((evt_pend & $past(rise)) == $past(rise))));

    // R6: a raised request points at an enabled, pending line
    a_r6_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int_en[irq_id] && int_pend[irq_id]));

    // R7: no enabled pending line sits above the selected one
    a_r7_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((masked >> irq_id) == 1));

    // R8: the vector is four bytes per line
    a_r8_vector_addr: assert property (@(posedge clk) disable iff (!rst_n)
        int'(irq_vec) == 4 * int'(irq_id));

    // R10: an enabled pending event drops the sleep request
    a_r10_sleep_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_en & evt_pend)) |=> !sleep_req);

    // R12: reset clears the state
    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (int_pend == '0 && evt_pend == '0 && int_en == '0 &&
                    evt_en == '0 && !sleep_req));
endmodule

bind irqc_top irqc_checker #(.NUM_LINES(NUM_LINES)) u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .int_en    (int_en),
    .int_pend  (int_pend),
    .evt_en    (evt_en),
    .evt_pend  (evt_pend),
    .irq_req   (irq_req),
    .irq_id    (irq_id),
    .irq_vec   (irq_vec),
    .sleep_req (sleep_req)
);

// File: tb/test_irqc_top.sv
// Bench: directed corners plus seeded random traffic, checked against a model.
module test_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_lines = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [4:0]  irq_id;
    logic [6:0]  irq_vec;
    logic        sleep_req;
    logic        wake;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    logic [31:0] m_ien = '0, m_ipend = '0, m_een = '0, m_epend = '0, m_prev = '0;
    logic        m_sleep = 1'b0;

    always #5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec),
        .sleep_req(sleep_req), .wake(wake)
    );

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return m_ien;
            6'h04: return m_ipend;
            6'h10: return m_een;
            6'h14: return m_epend;
            6'h20: return {31'b0, m_sleep};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [4:0] m_id();
        logic [4:0] r = '0;
        for (int i = 0; i < 32; i++) if (m_ien[i] & m_ipend[i]) r = 5'(i);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v,
                       input string what);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
        end
    endtask

    // Apply the model of one clock edge
    task automatic m_update(input logic we, input logic [5:0] a, input logic [31:0] d,
                            input logic [31:0] ln);
        logic [31:0] rise = ln & ~m_prev;
        logic        hit  = |(m_een & m_epend);
        logic [31:0] iset = (we && a == 6'h08) ? d : '0;
        logic [31:0] iclr = (we && a == 6'h0C) ? d : '0;
        logic [31:0] eset = (we && a == 6'h18) ? d : '0;
        logic [31:0] eclr = (we && a == 6'h1C) ? d : '0;
        m_ipend = ((m_ipend | iset) & ~iclr) | rise;
        m_epend = ((m_epend | eset) & ~eclr) | rise;
        if (we && a == 6'h00) m_ien = d;
        if (we && a == 6'h10) m_een = d;
        if (hit) m_sleep = 1'b0;
        else if (we && a == 6'h20) m_sleep = d[0];
        m_prev = ln;
    endtask

    // One cycle: drive at negedge, check just after posedge
    task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d,
                        input logic [31:0] ln, input string rtag);
        bus_we = we; bus_addr = a; bus_wdata = d; req_lines = ln;
        m_update(we, a, d, ln);
        @(posedge clk); #1;
        chk("R6", 32'(irq_req), 32'(|(m_ien & m_ipend)), "irq_req");
        chk("R7", 32'(irq_id), 32'(m_id()), "irq_id");
        chk("R8", 32'(irq_vec), 32'(m_id()) * 4, "irq_vec");
        chk("R10", 32'(sleep_req), 32'(m_sleep), "sleep_req");
        chk("R10", 32'(wake), 32'(m_sleep & (|(m_een & m_epend))), "wake");
        chk(rtag, bus_rdata, m_read(a), "bus_rdata");
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        step(1'b0, a, 32'h0, req_lines, tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, req_lines, tag);
    endtask

    // Watchdog
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] ofs [10] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                                 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24};
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12", 32'({irq_req, sleep_req, wake}), 32'h0, "outputs after reset");
        rd(6'h00, "R12"); rd(6'h04, "R12"); rd(6'h10, "R12");
        rd(6'h14, "R12"); rd(6'h20, "R12");

        // R2: enables read back, write-only offsets read zero
        wr(6'h00, 32'h8080_0001, "R2");
        rd(6'h00, "R2"); rd(6'h08, "R2"); rd(6'h24, "R2");

        // R1: edge on line 23 pends in both banks
        step(1'b0, 6'h14, 32'h0, 32'h0080_0000, "R1");
        chk("R8", 32'(irq_vec), 32'h5C, "line 23 vector");
        rd(6'h04, "R1");
        // R7: line 31 beats line 23
        step(1'b0, 6'h04, 32'h0, 32'h8080_0000, "R7");
        chk("R8", 32'(irq_vec), 32'h7C, "line 31 vector");
        // R4: clear only line 31 in the interrupt bank
        wr(6'h0C, 32'h8000_0000, "R4");
        rd(6'h14, "R4");
        // R1: level held, cleared bit stays clear
        wr(6'h0C, 32'h0080_0000, "R1");
        rd(6'h04, "R1");
        chk("R6", 32'(irq_req), 32'h0, "nothing pending");
        // R6: pending but disabled line does nothing
        step(1'b0, 6'h04, 32'h0, 32'h8080_0010, "R6");
        // R5: clear and new edge on line 0 in same cycle
        step(1'b0, 6'h04, 32'h0, 32'h0, "R5");
        step(1'b1, 6'h0C, 32'h0000_0001, 32'h0000_0001, "R5");
        rd(6'h04, "R5");
        // R3: set-pending writes
        wr(6'h08, 32'h0000_0F00, "R3"); rd(6'h04, "R3");
        wr(6'h18, 32'h00F0_0000, "R3"); rd(6'h14, "R3");
        // R11: writes to pending offsets ignored
        wr(6'h04, 32'hFFFF_FFFF, "R11"); rd(6'h04, "R11");
        wr(6'h14, 32'h0, "R11"); rd(6'h14, "R11");
        // R9: sleep write and readback, no events enabled
        wr(6'h20, 32'h1, "R9"); rd(6'h20, "R9");
        // R10: event pending but not enabled keeps sleep
        rd(6'h20, "R10");
        // R10: enabling a pending event releases sleep
        wr(6'h10, 32'h0010_0000, "R10");
        rd(6'h20, "R10");
        // R10: sleep write while enabled event pending is overridden
        wr(6'h20, 32'h1, "R10"); rd(6'h20, "R10");
        wr(6'h1C, 32'hFFFF_FFFF, "R4");
        wr(6'h20, 32'h1, "R9"); rd(6'h20, "R9");
        step(1'b0, 6'h20, 32'h0, 32'h0010_0000, "R10");
        rd(6'h20, "R10");

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [5:0]  a  = ofs[$urandom_range(0, 9)];
            logic        we = $urandom_range(0, 1) == 1;
            logic [31:0] d  = $urandom() & $urandom();
            logic [31:0] ln = req_lines ^ ($urandom() & $urandom() & $urandom());
            if (a == 6'h20) d = {31'b0, d[0] | d[5]};
            step(we, a, d, ln, "R2");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule